// File: doc/BRIEF.md
# Trap Entry Status-Exchange Sequencer

This block carries out the hardware side of trap entry for a simple processor model. When the processor detects a trap, it presents a request together with a two-bit cause code, the faulting virtual page and its current program status. The block then takes over a single-word memory port. First it reads the exchange instruction stored at the fixed trap vector. Next it saves the current status words to the save area that instruction names. If the instruction is the register-saving variant, it also saves all general registers. Finally it loads the handler's status words from memory.

The freshly loaded status is then adjusted before it is committed. A cause-specific set of condition code bits is forced to one, and all other bits keep their loaded values. If the instruction's AI flag is set, a cause-specific step is added to the program counter, so that the handler can dispatch through a jump table. For protection and write lock faults, the faulting page is written into the fourth saved status word. The block holds `busy` high for the whole exchange. It ignores further requests during that time and marks completion with a one-cycle `done` pulse.

Status word 0 layout: bits [31:28] are the condition codes CC1..CC4, with CC1 at bit 31, and bits [PC_W-1:0] are the program counter. Exchange instruction layout: bits [31:24] are the opcode, bit 22 is the AI flag, and bits [AW-1:0] are the save area base address.

Top module: `trap_entry_seq`

## Requirements
- R1: A request accepted while idle raises `busy` at the next clock edge, and the first memory access of every sequence is a read of address 0x40, whatever the cause.
- R2: After that read, the block makes 4 writes of the current status words to base..base+3, word 0 first. Only when the fetched opcode equals 0x0B, it then makes 16 general-register writes to base+4..base+19 in register order. It ends with 4 reads from base+4, or from base+20 for opcode 0x0B.
- R3: The saved status words equal `cur_psw` as sampled at acceptance. For causes 0 and 1, word 3 is stored unaltered, so a privileged-instruction trap saves the status of the trapped instruction exactly.
- R4: For causes 2 (protection) and 3 (write lock), the low PAGE_W bits of saved word 3 are replaced by `fault_page`, and its upper bits are kept.
- R5: The committed status sets CC2 (bit 30) for cause 0, CC3 (bit 29) for cause 1, CC4 (bit 28) for cause 2, and CC3 and CC4 for cause 3. Every other bit of every word equals the loaded value, apart from the PC change of R6.
- R6: When AI (instruction bit 22) is 1, the PC field of word 0 is increased modulo 2^PC_W by 4, 2, 1 or 3 for causes 0, 1, 2 or 3. When AI is 0, the PC field is left as loaded.
- R7: `busy` stays high from acceptance until commit. `done` is a one-cycle pulse in the cycle in which `busy` has just fallen, and `new_psw` holds the committed status from then on. While idle, no memory request is made.
- R8: Requests, causes, pages and status inputs presented while `busy` is high do not alter the running sequence or its result.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.
- R10: During and right after reset, `busy`, `done` and `mem_valid` are 0 and `new_psw` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Trap request, sampled while idle |
| trap_cause | input | 2 | 0 nonexistent address, 1 privileged in slave mode, 2 protection, 3 write lock |
| fault_page | input | PAGE_W (8) | Faulting virtual page |
| cur_psw | input | 4*32 (128) | Current status words, word 0 in the low bits |
| gpr_sel | output | log2(NGPR) (4) | General register being saved |
| gpr_data | input | 32 | Contents of the selected register |
| mem_valid | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW (17) | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted at this edge |
| mem_rdata | input | 32 | Read data, valid in the cycle after acceptance |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| new_psw | output | 4*32 (128) | Committed, adjusted status words |

## Verification
The bench uses the default parameters: 16 registers, a 17-bit address and PC, and an 8-bit page field. The 17-bit PC lets a directed case wrap the counter from 0x1FFFF. Placing save areas in the low 256 words gives the memory model a small array that still keeps every save and load region apart from the vector at 0x40. With these values every cause, both instruction variants and both AI settings are reachable. The runs use both random and always-ready handshakes, and the 20-word register save gives long stretches of stalls.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int WORD_W = 32;
  localparam int CC_HI  = 31;   // CC1 at 31 .. CC4 at 28
  localparam int AI_POS = 22;
  localparam int OP_HI  = 31;
  localparam int OP_LO  = 24;

  typedef enum logic [1:0] {
    CAUSE_NOADDR = 2'd0,
    CAUSE_PRIV   = 2'd1,
    CAUSE_PROT   = 2'd2,
    CAUSE_WLOCK  = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_FETCH_CAP, ST_SAVE_PSW,
    ST_SAVE_GPR, ST_LOAD, ST_LOAD_CAP, ST_COMMIT
  } seq_state_e;

  // condition code bits forced to one, ordered CC1..CC4
  function automatic logic [3:0] cc_set_mask(cause_e c);
    case (c)
      CAUSE_NOADDR: return 4'b0100;
      CAUSE_PRIV:   return 4'b0010;
      CAUSE_PROT:   return 4'b0001;
      default:      return 4'b0011;
    endcase
  endfunction

  function automatic logic [2:0] pc_step(cause_e c);
    case (c)
      CAUSE_NOADDR: return 3'd4;
      CAUSE_PRIV:   return 3'd2;
      CAUSE_PROT:   return 3'd1;
      default:      return 3'd3;
    endcase
  endfunction

  function automatic logic page_reported(cause_e c);
    return (c == CAUSE_PROT) || (c == CAUSE_WLOCK);
  endfunction
endpackage

// File: rtl/trap_psw_buf.sv
module trap_psw_buf import trap_pkg::*; #(
  parameter int WORDS = 4,
  localparam int SEL_W = $clog2(WORDS)
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [SEL_W-1:0]          widx,
  input  logic [WORD_W-1:0]         wdata,
  output logic [WORDS*WORD_W-1:0]   words
);
  logic [WORD_W-1:0] store_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) store_q[widx] <= wdata;
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_flat
    assign words[w*WORD_W +: WORD_W] = store_q[w];
  end
endmodule

// File: rtl/trap_adjust.sv
module trap_adjust import trap_pkg::*; #(
  parameter int WORDS = 4,
  parameter int PC_W  = 17
) (
  input  logic [WORDS*WORD_W-1:0] loaded,
  input  cause_e                  cause,
  input  logic                    ai,
  output logic [WORDS*WORD_W-1:0] adjusted
);
  logic [WORD_W-1:0] lead;

  always_comb begin
    lead = loaded[WORD_W-1:0];
    lead[CC_HI -: 4] = lead[CC_HI -: 4] | cc_set_mask(cause);
    if (ai) lead[PC_W-1:0] = lead[PC_W-1:0] + PC_W'(pc_step(cause));
  end

  assign adjusted[WORD_W-1:0] = lead;
  for (genvar w = 1; w < WORDS; w++) begin : g_pass
    assign adjusted[w*WORD_W +: WORD_W] = loaded[w*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq import trap_pkg::*; #(
  parameter int          PSW_WORDS = 4,
  parameter int          NGPR      = 16,
  parameter int          AW        = 17,
  parameter int          PC_W      = 17,
  parameter int          PAGE_W    = 8,
  parameter int unsigned TRAP_ADDR = 32'h40,
  parameter logic [7:0]  OP_SAVE   = 8'h0B
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          trap_req,
  input  logic [1:0]                    trap_cause,
  input  logic [PAGE_W-1:0]             fault_page,
  input  logic [PSW_WORDS*WORD_W-1:0]   cur_psw,
  output logic [$clog2(NGPR)-1:0]       gpr_sel,
  input  logic [WORD_W-1:0]             gpr_data,
  output logic                          mem_valid,
  output logic                          mem_we,
  output logic [AW-1:0]                 mem_addr,
  output logic [WORD_W-1:0]             mem_wdata,
  input  logic                          mem_ready,
  input  logic [WORD_W-1:0]             mem_rdata,
  output logic                          busy,
  output logic                          done,
  output logic [PSW_WORDS*WORD_W-1:0]   new_psw
);
  localparam int PSW_BITS = PSW_WORDS * WORD_W;
  localparam int WSEL_W   = $clog2(PSW_WORDS);
  localparam int GSEL_W   = $clog2(NGPR);
  localparam int IDX_W    = (GSEL_W > WSEL_W) ? GSEL_W : WSEL_W;
  localparam logic [AW-1:0] VEC_ADDR = AW'(TRAP_ADDR);

  seq_state_e            state_q;
  cause_e                cause_q;
  logic [PSW_BITS-1:0]   saved_q;
  logic [PSW_BITS-1:0]   snap_psw;
  logic [IDX_W-1:0]      idx_q;
  logic                  save_regs_q;
  logic                  ai_q;
  logic [AW-1:0]         base_q;
  logic [AW-1:0]         load_base;
  logic [WORD_W-1:0]     saved_word;
  logic                  fire;
  logic                  last_psw, last_gpr;
  logic [PSW_BITS-1:0]   loaded_words;
  logic [PSW_BITS-1:0]   adjusted_words;

  // snapshot of the current status, fault page folded into the last word
  always_comb begin
    snap_psw = cur_psw;
    if (page_reported(cause_e'(trap_cause)))
      snap_psw[(PSW_WORDS-1)*WORD_W +: PAGE_W] = fault_page;
  end

  assign saved_word = saved_q[idx_q[WSEL_W-1:0]*WORD_W +: WORD_W];
  assign load_base  = base_q + AW'(PSW_WORDS) + (save_regs_q ? AW'(NGPR) : '0);
  assign last_psw   = (idx_q == IDX_W'(PSW_WORDS-1));
  assign last_gpr   = (idx_q == IDX_W'(NGPR-1));
  assign gpr_sel    = idx_q[GSEL_W-1:0];
  assign fire       = mem_valid && mem_ready;

  // memory request decoded from state registers
  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state_q)
      ST_FETCH: begin
        mem_valid = 1'b1;
        mem_addr  = VEC_ADDR;
      end
      ST_SAVE_PSW: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = base_q + AW'(idx_q);
        mem_wdata = saved_word;
      end
      ST_SAVE_GPR: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = base_q + AW'(PSW_WORDS) + AW'(idx_q);
        mem_wdata = gpr_data;
      end
      ST_LOAD: begin
        mem_valid = 1'b1;
        mem_addr  = load_base + AW'(idx_q);
      end
      default: ;
    endcase
  end

  trap_psw_buf #(.WORDS(PSW_WORDS)) u_buf (
    .clk   (clk),
    .we    (state_q == ST_LOAD_CAP),
    .widx  (idx_q[WSEL_W-1:0]),
    .wdata (mem_rdata),
    .words (loaded_words)
  );

  trap_adjust #(.WORDS(PSW_WORDS), .PC_W(PC_W)) u_adj (
    .loaded   (loaded_words),
    .cause    (cause_q),
    .ai       (ai_q),
    .adjusted (adjusted_words)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cause_q     <= CAUSE_NOADDR;
      saved_q     <= '0;
      idx_q       <= '0;
      save_regs_q <= 1'b0;
      ai_q        <= 1'b0;
      base_q      <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      new_psw     <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: if (trap_req) begin
          cause_q <= cause_e'(trap_cause);
          saved_q <= snap_psw;
          busy    <= 1'b1;
          state_q <= ST_FETCH;
        end
        ST_FETCH: if (fire) state_q <= ST_FETCH_CAP;
        ST_FETCH_CAP: begin
          save_regs_q <= (mem_rdata[OP_HI:OP_LO] == OP_SAVE);
          ai_q        <= mem_rdata[AI_POS];
          base_q      <= mem_rdata[AW-1:0];
          idx_q       <= '0;
          state_q     <= ST_SAVE_PSW;
        end
        ST_SAVE_PSW: if (fire) begin
          if (last_psw) begin
            idx_q   <= '0;
            state_q <= save_regs_q ? ST_SAVE_GPR : ST_LOAD;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_SAVE_GPR: if (fire) begin
          if (last_gpr) begin
            idx_q   <= '0;
            state_q <= ST_LOAD;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_LOAD: if (fire) state_q <= ST_LOAD_CAP;
        ST_LOAD_CAP: begin
          if (last_psw) begin
            state_q <= ST_COMMIT;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_LOAD;
          end
        end
        ST_COMMIT: begin
          new_psw <= adjusted_words;
          done    <= 1'b1;
          busy    <= 1'b0;
          idx_q   <= '0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // the first access after acceptance is the vector read
  assert_vector_first_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (mem_valid && !mem_we && mem_addr == VEC_ADDR));

  // requests stay put until accepted
  assert_hold_request_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_valid);

  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_cause_locked_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cause_q));

  assert_cc_forced_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> ((new_psw[CC_HI -: 4] & cc_set_mask(cause_q)) == cc_set_mask(cause_q)));
endmodule

// File: tb/sim_trap_entry_seq.sv
module sim_trap_entry_seq;
  localparam int PW = 4;
  localparam int NG = 16;
  localparam int AW = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trap_req = 1'b0;
  logic [1:0] trap_cause = '0;
  logic [7:0] fault_page = '0;
  logic [127:0] cur_psw = '0;
  logic [3:0] gpr_sel;
  logic [31:0] gpr_data;
  logic mem_valid, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic mem_ready = 1'b1;
  logic [31:0] mem_rdata = '0;
  logic busy, done;
  logic [127:0] new_psw;

  always #2 clk = ~clk;

  trap_entry_seq u0 (
    .clk(clk), .rst(rst), .trap_req(trap_req), .trap_cause(trap_cause),
    .fault_page(fault_page), .cur_psw(cur_psw), .gpr_sel(gpr_sel),
    .gpr_data(gpr_data), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .new_psw(new_psw)
  );

  logic [31:0] mem [0:255];
  logic [31:0] gprs [0:15];
  assign gpr_data = gprs[gpr_sel];

  int n_chk = 0, n_fail = 0;
  bit rnd_ready = 1'b0;
  logic sv_valid = 1'b0, sv_ready = 1'b0, sv_we = 1'b0;
  logic [AW-1:0] sv_addr = '0;
  logic [31:0] sv_wdata = '0;
  logic lg_we [0:39];
  logic [AW-1:0] lg_addr [0:39];
  logic [31:0] lg_wd [0:39];
  int lg_n = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // handshake model, monitor and memory, all at the falling edge
  always @(negedge clk) begin
    if (!rst && sv_valid && !sv_ready)
      chk(mem_valid && mem_addr == sv_addr && mem_we == sv_we && mem_wdata == sv_wdata,
          "R9 request held", {mem_valid, mem_we, mem_addr, mem_wdata},
          {1'b1, sv_we, sv_addr, sv_wdata});
    mem_ready = rnd_ready ? (($urandom % 3) != 0) : 1'b1;
    sv_valid = mem_valid; sv_ready = mem_ready; sv_we = mem_we;
    sv_addr = mem_addr; sv_wdata = mem_wdata;
    if (mem_valid && mem_ready) begin
      if (lg_n < 40) begin
        lg_we[lg_n] = mem_we; lg_addr[lg_n] = mem_addr; lg_wd[lg_n] = mem_wdata;
      end
      lg_n++;
      if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
      else mem_rdata = mem[mem_addr[7:0]];
    end
  end

  function automatic logic [3:0] exp_mask(input logic [1:0] c);
    case (c)
      2'd0: return 4'b0100;
      2'd1: return 4'b0010;
      2'd2: return 4'b0001;
      default: return 4'b0011;
    endcase
  endfunction

  function automatic logic [16:0] exp_step(input logic [1:0] c);
    case (c)
      2'd0: return 17'd4;
      2'd1: return 17'd2;
      2'd2: return 17'd1;
      default: return 17'd3;
    endcase
  endfunction

  task automatic run_trap(input logic [1:0] cause, input bit ai, input bit save,
                          input logic [16:0] pc, input bit spurious);
    logic [7:0] base, ldb, page;
    logic [31:0] inst;
    logic [127:0] cur, sv, nw, en;
    int w, cnt, j;
    base = 8'h50 + 8'($urandom % 8'h90);
    page = 8'($urandom);
    ldb  = base + 8'd4 + (save ? 8'd16 : 8'd0);
    inst = {(save ? 8'h0B : 8'h0F), 1'b0, ai, 5'b0, 17'(base)};
    mem[8'h40] = inst;
    for (int i = 0; i < 24; i++) mem[8'(base + 8'(i))] = 32'hDEAD_0000 + i;
    for (int i = 0; i < 4; i++) begin
      nw[i*32 +: 32] = $urandom;
      if (i == 0) nw[16:0] = pc;
      mem[8'(ldb + 8'(i))] = nw[i*32 +: 32];
    end
    for (int i = 0; i < 16; i++) gprs[i] = $urandom;
    cur = {$urandom, $urandom, $urandom, $urandom};
    sv = cur;
    if (cause >= 2'd2) sv[96 +: 8] = page;
    en = nw;
    en[31:28] = en[31:28] | exp_mask(cause);
    if (ai) en[16:0] = en[16:0] + exp_step(cause);

    @(negedge clk);
    lg_n = 0;
    trap_req = 1'b1; trap_cause = cause; fault_page = page; cur_psw = cur;
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy after accept", 128'(busy), 128'd1);
    if (spurious) begin
      trap_cause = cause ^ 2'd1; fault_page = ~page; cur_psw = ~cur;
      repeat (3) @(negedge clk);
    end
    trap_req = 1'b0;
    w = 0;
    while (!done && w < 400) begin @(negedge clk); w++; end
    chk(done == 1'b1, "R7 done seen", 128'(done), 128'd1);
    chk(busy == 1'b0, "R7 busy low at done", 128'(busy), 128'd0);
    chk(new_psw[31:28] == en[31:28], "R5 condition codes", 128'(new_psw[31:28]),
        128'(en[31:28]));
    chk(new_psw[16:0] == en[16:0], "R6 program counter", 128'(new_psw[16:0]),
        128'(en[16:0]));
    chk(new_psw[127:32] == en[127:32] && new_psw[27:17] == en[27:17],
        "R5 untouched bits", new_psw, en);
    if (spurious) chk(new_psw == en, "R8 ignored while busy", new_psw, en);
    cnt = 1 + 4 + (save ? 16 : 0) + 4;
    chk(lg_n == cnt, "R2 access count", 128'(lg_n), 128'(cnt));
    if (lg_n == cnt) begin
      chk(!lg_we[0] && lg_addr[0] == 17'h40, "R1 vector read",
          {lg_we[0], lg_addr[0]}, {1'b0, 17'h40});
      for (j = 0; j < 4; j++) begin
        chk(lg_we[1+j] && lg_addr[1+j] == 17'(base) + 17'(j), "R2 status save address",
            {lg_we[1+j], lg_addr[1+j]}, {1'b1, 17'(base) + 17'(j)});
        chk(lg_wd[1+j] == sv[j*32 +: 32], (j == 3 && cause >= 2'd2) ? "R4 page in word 3" :
            "R3 saved status", 128'(lg_wd[1+j]), 128'(sv[j*32 +: 32]));
      end
      if (save)
        for (j = 0; j < 16; j++)
          chk(lg_we[5+j] && lg_addr[5+j] == 17'(base) + 17'd4 + 17'(j) &&
              lg_wd[5+j] == gprs[j], "R2 register save",
              {lg_we[5+j], lg_addr[5+j], lg_wd[5+j]},
              {1'b1, 17'(base) + 17'd4 + 17'(j), gprs[j]});
      for (j = 0; j < 4; j++)
        chk(!lg_we[cnt-4+j] && lg_addr[cnt-4+j] == 17'(ldb) + 17'(j), "R2 status load",
            {lg_we[cnt-4+j], lg_addr[cnt-4+j]}, {1'b0, 17'(ldb) + 17'(j)});
    end
    @(negedge clk);
    chk(done == 1'b0 && new_psw == en, "R7 pulse and hold", {done, new_psw[126:0]},
        {1'b0, en[126:0]});
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 16; i++) gprs[i] = '0;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !mem_valid && new_psw == '0, "R10 in reset",
        {busy, done, mem_valid}, 128'd0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !mem_valid && new_psw == '0, "R10 after reset",
        {busy, done, mem_valid}, 128'd0);
    // directed: every cause, both AI values, both variants
    for (int c = 0; c < 4; c++) begin
      run_trap(2'(c), 1'b0, 1'b0, 17'h00100, 1'b0);
      run_trap(2'(c), 1'b1, 1'b1, 17'h00200, 1'b0);
    end
    run_trap(2'd0, 1'b1, 1'b0, 17'h1FFFF, 1'b0);   // R6 wrap to 3
    run_trap(2'd3, 1'b1, 1'b0, 17'h1FFFE, 1'b1);   // R6 wrap, R8
    run_trap(2'd1, 1'b0, 1'b1, 17'h0ABCD, 1'b1);   // R3 privileged, R8
    rnd_ready = 1'b1;
    for (int k = 0; k < 40; k++)
      run_trap(2'($urandom), 1'($urandom), 1'($urandom), 17'($urandom),
               ($urandom % 4) == 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule